// File: doc/BRIEF.md
# Skip-Sequence Three-Bit Counter

This block is a synchronous three-bit state machine. On every clock edge it moves one step through a fixed loop of five codes, 0, 3, 5, 7, 6 and back to 0. No adder computes the next code. Each of the three state bits has its own pair of set/clear controls (J and K) that follow the JK flip-flop rule: with J=0,K=0 the bit holds, with J=0,K=1 it clears, with J=1,K=0 it sets, and with J=1,K=1 it toggles. The control terms were minimised with the three codes outside the loop (1, 2 and 4) taken as don't-care.

The minimised terms still decide where those three codes go. In this design code 1 steps to 3, code 2 steps to 5, and code 4 steps to 2 and then to 5. A register upset into an unused code therefore rejoins the loop within two clocks. A one-cycle wrap flag marks the last step of each loop, which makes the block usable as a divide-by-five phase source.

Top module: `jk_skip_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` reads 0 after that edge, whatever code was held before. `wrap` is low while `state` is 0.
- R2: With `rst` low, each rising edge moves `state` from 0 to 3, from 3 to 5, from 5 to 7, from 7 to 6, and from 6 back to 0.
- R3: With `rst` low, a held unused code 1 (binary 001) becomes 3 at the next edge.
- R4: With `rst` low, a held unused code 2 (binary 010) becomes 5 at the next edge.
- R5: With `rst` low, a held unused code 4 (binary 100) becomes 2 at the next edge and 5 at the edge after that, so it is back in the loop within two clocks.
- R6: `wrap` is high in exactly those cycles in which `state` is 6. The code that follows a high `wrap` is 0.
- R7: `wrap` is low while `state` holds any of the unused codes 1, 2 or 4, and also while it holds 0, 3, 5 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to code 0 |
| state | output | 3 | Current state code |
| wrap | output | 1 | High for the one cycle in which state is 6 |

## Verification
A wrong J or K term on any bit shows up at `state` on the very next edge. It appears either as a wrong successor inside the loop or as a wrong landing code after an unused value is injected. A bad term for code 4 can sit hidden for one extra cycle, because its path passes through code 2 first, so that case is checked on both following edges. A decode fault in `wrap` is visible in the same cycle as the state it belongs to.

// File: rtl/jk_skip_pkg.sv
`timescale 1ns/1ps
package jk_skip_pkg;
    localparam int STW = 3;
    localparam int NCODES = 1 << STW;

    typedef logic [STW-1:0] code_t;

    typedef struct packed {
        logic j;
        logic k;
    } jk_t;

    localparam code_t CODE_HOME = 3'd0;
    localparam code_t CODE_WRAP = 3'd6;

    function automatic logic jk_apply(input logic q, input jk_t c);
        logic r;
        case ({c.j, c.k})
            2'b00:   r = q;
            2'b01:   r = 1'b0;
            2'b10:   r = 1'b1;
            default: r = ~q;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/jk_skip_excite.sv
`timescale 1ns/1ps
module jk_skip_excite
    import jk_skip_pkg::*;
(
    input  code_t              q,
    output jk_t   [STW-1:0]    ctl
);
    always_comb begin
        ctl[2].j = q[1];
        ctl[2].k = ~q[0];
        ctl[1].j = 1'b1;
        ctl[1].k = ~(q[2] & q[0]);
        ctl[0].j = ~q[2];
        ctl[0].k = q[2] & q[1];
    end
endmodule

// File: rtl/jk_skip_bank.sv
`timescale 1ns/1ps
module jk_skip_bank
    import jk_skip_pkg::*;
(
    input  code_t            q,
    input  jk_t   [STW-1:0]  ctl,
    output code_t            d
);
    for (genvar i = 0; i < STW; i++) begin : g_bit
        assign d[i] = jk_apply(q[i], ctl[i]);
    end
endmodule

// File: rtl/jk_skip_counter.sv
`timescale 1ns/1ps
module jk_skip_counter
    import jk_skip_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    output logic [STW-1:0] state,
    output logic           wrap
);
    code_t            state_q;
    code_t            nxt_state;
    jk_t   [STW-1:0]  ctl;

    jk_skip_excite u_excite (
        .q   (state_q),
        .ctl (ctl)
    );

    jk_skip_bank u_bank (
        .q   (state_q),
        .ctl (ctl),
        .d   (nxt_state)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= CODE_HOME;
        else     state_q <= nxt_state;
    end

    assign state = state_q;
    assign wrap  = (state_q == CODE_WRAP);
endmodule

// File: rtl/jk_skip_counter_chk.sv
`timescale 1ns/1ps
module jk_skip_counter_chk
    import jk_skip_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input code_t state_q,
    input code_t nxt,
    input logic  wrap
);
    function automatic code_t loop_next(input code_t c);
        case (c)
            3'd0:    return 3'd3;
            3'd3:    return 3'd5;
            3'd5:    return 3'd7;
            3'd7:    return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    a_r1_reset_home: assert property (@(posedge clk)
        rst |=> (state_q == 3'd0));

    a_r2_loop_step: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {3'd0, 3'd3, 3'd5, 3'd7, 3'd6}) |-> (nxt == loop_next(state_q)));

    a_r3_code1_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'd1) |-> (nxt == 3'd3));

    a_r4_code2_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'd2) |-> (nxt == 3'd5));

    a_r5_code4_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'd4) |-> (nxt == 3'd2));

    a_r6_wrap_to_home: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (nxt == 3'd0));

    a_r6_home_needs_wrap: assert property (@(posedge clk) disable iff (rst)
        (nxt == 3'd0) |-> wrap);

    a_r7_unused_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {3'd1, 3'd2, 3'd4}) |-> !wrap);
endmodule

bind jk_skip_counter jk_skip_counter_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .state_q (state_q),
    .nxt     (nxt_state),
    .wrap    (wrap)
);

// File: tb/jk_skip_counter_tb.sv
`timescale 1ns/1ps
module jk_skip_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] state;
    logic       wrap;
    int         total = 0;
    int         bad = 0;
    logic [2:0] exp_st;
    bit         prev_rst;

    jk_skip_counter u_dut (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .wrap  (wrap)
    );

    always #5 clk = ~clk;

    function automatic logic [2:0] model_next(input logic [2:0] c);
        case (c)
            3'd0: return 3'd3;
            3'd3: return 3'd5;
            3'd5: return 3'd7;
            3'd7: return 3'd6;
            3'd6: return 3'd0;
            3'd1: return 3'd3;
            3'd2: return 3'd5;
            default: return 3'd2;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] prior);
        case (prior)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd4: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req);
        check(req, state, exp_st);
        check((exp_st == 3'd6) ? "R6" : "R7", wrap, (exp_st == 3'd6) ? 1 : 0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic inject(input logic [2:0] c);
        force u_dut.state_q = c;
        #1;
        release u_dut.state_q;
        exp_st = c;
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_0C3B));
        rst = 1'b1;
        step();
        step();
        exp_st = 3'd0;
        check_out("R1");
        rst = 1'b0;

        // R2 directed: two full loops, wrap seen at code 6 (R6)
        for (int i = 0; i < 10; i++) begin
            step();
            exp_st = model_next(exp_st);
            check_out("R2");
        end

        // unused codes, one and two clocks after injection
        for (int n = 0; n < 3; n++) begin
            logic [2:0] c;
            c = (n == 0) ? 3'd1 : (n == 1) ? 3'd2 : 3'd4;
            inject(c);
            check_out("R7");
            step();
            exp_st = model_next(c);
            check_out(tag_of(c));
            step();
            exp_st = model_next(exp_st);
            check((c == 3'd4) ? "R5" : "R2", state, exp_st);
            check("R5 back in loop", (state inside {3'd0, 3'd3, 3'd5, 3'd7, 3'd6}) ? 1 : 0, 1);
        end

        // R1: reset wins over an unused code
        inject(3'd4);
        rst = 1'b1;
        step();
        exp_st = 3'd0;
        check_out("R1");
        rst = 1'b0;
        step();
        exp_st = 3'd3;
        check_out("R2");
        prev_rst = 1'b0;

        // random mix of runs, resets and injections
        for (int it = 0; it < 400; it++) begin
            int unsigned r;
            r = $urandom_range(0, 9);
            if (r == 0 && !prev_rst) begin
                rst = 1'b1;
                step();
                exp_st = 3'd0;
                check_out("R1");
                rst = 1'b0;
                prev_rst = 1'b1;
            end else if (r <= 2 && !prev_rst) begin
                inject(3'($urandom_range(0, 7)));
                check_out("R7");
                prev_rst = 1'b0;
            end else begin
                logic [2:0] prior;
                prior = exp_st;
                step();
                exp_st = model_next(prior);
                check_out(tag_of(prior));
                prev_rst = 1'b0;
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule